// File: doc/BRIEF.md
# Lockable Seconds Counter Register Window

This block keeps a 32-bit count of seconds and presents it to a processor through three word-spaced registers decoded from the low byte of the address: one for the upper half of the count, one for the lower half, and one for a write-enable latch. A one-cycle `tick` strobe advances the count by one, and the count wraps to zero after its maximum.

Software sets the latch before it changes the time. While the latch is set, a write to the lower half replaces those 16 bits and leaves the latch set. A write to the upper half replaces those 16 bits and clears the latch, so the usual sequence is: unlock, write the low half, write the high half. While the latch is clear, writes to either half are dropped. Reads of the two halves return the 16 bits zero-extended to 32. A write to an address outside the window produces a one-cycle `invalid_access` pulse.

Top module: `rtc_regwin`

## Requirements
- R1: After reset the count is zero, the enable latch is clear and `invalid_access` is low.
- R2: With `bus_addr` low byte 0x00, `bus_rdata` shows count[31:16] in bits 15:0 with bits 31:16 zero. With low byte 0x04 it shows count[15:0] the same way. Reads are combinational and have no side effect.
- R3: A read at low byte 0x08, or at any low byte other than 0x00 and 0x04, returns zero.
- R4: A write at low byte 0x08 loads the enable latch from `bus_wdata[0]`.
- R5: A write at low byte 0x00 while the latch is set replaces count[31:16] with `bus_wdata` and clears the latch.
- R6: A write at low byte 0x04 while the latch is set replaces count[15:0] with `bus_wdata` and leaves the latch set.
- R7: A write to either half while the latch is clear leaves the count unchanged apart from any tick.
- R8: Each clock cycle with `tick` high and no accepted half write adds one to the count, wrapping from 0xFFFFFFFF to 0.
- R9: If an accepted half write and a tick fall in the same cycle, the write takes effect and the tick is dropped.
- R10: A write to any low byte other than 0x00, 0x04 and 0x08 raises `invalid_access` for exactly the cycle that follows it. Writes to mapped offsets never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe, once per second |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_addr | input | ADDR_W (8) | Byte address. The low 8 bits are decoded. |
| bus_wdata | input | HALF_W (16) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| invalid_access | output | 1 | One-cycle pulse after a write to an unmapped offset |

## Verification
Every write and tick takes effect at the clock edge where it is sampled. The count reaches the read port combinationally, so the new half values can be read in the low phase that follows that edge. `invalid_access` is registered, so it is high in that same low phase and must be low again one cycle later. The bench drives each operation at a falling edge and samples at the next falling edge, after exactly one rising edge. It then reads both halves and the unmapped offsets while the strobes are low, so that a read never coincides with a write.

// File: rtl/rtc_regwin_pkg.sv
package rtc_regwin_pkg;

  localparam int DEC_W = 8;

  localparam logic [DEC_W-1:0] OFS_HI = 8'h00;
  localparam logic [DEC_W-1:0] OFS_LO = 8'h04;
  localparam logic [DEC_W-1:0] OFS_EN = 8'h08;

  typedef enum logic [1:0] {
    SEL_HI   = 2'd0,
    SEL_LO   = 2'd1,
    SEL_EN   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [DEC_W-1:0] ofs);
    case (ofs)
      OFS_HI:  return SEL_HI;
      OFS_LO:  return SEL_LO;
      OFS_EN:  return SEL_EN;
      default: return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/rtc_addr_decode.sv
module rtc_addr_decode
  import rtc_regwin_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb sel = decode_ofs(addr[DEC_W-1:0]);

  initial begin
    assert (ADDR_W >= DEC_W) else $error("ADDR_W must cover the decoded byte");
  end
endmodule

// File: rtl/rtc_wen_latch.sv
module rtc_wen_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic en_wr,
  input  logic en_bit,
  input  logic hi_commit,
  output logic en
);
  always_ff @(posedge clk) begin
    if (!rst_n)         en <= 1'b0;
    else if (en_wr)     en <= en_bit;
    else if (hi_commit) en <= 1'b0;
  end

  // R4
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> en == $past(en_bit));
  // R5
  en_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_commit |=> !en);
  // R6
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_wr && !hi_commit) |=> $stable(en));
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int HALF_W = 16,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic [HALF_W-1:0] ld_data,
  output logic [CNT_W-1:0]  count
);
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] merge_hi(input logic [CNT_W-1:0] c,
                                                input logic [HALF_W-1:0] d);
    return {d, c[HALF_W-1:0]};
  endfunction

  function automatic logic [CNT_W-1:0] merge_lo(input logic [CNT_W-1:0] c,
                                                input logic [HALF_W-1:0] d);
    return {c[CNT_W-1:HALF_W], d};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (ld_hi) count <= merge_hi(count, ld_data);
    else if (ld_lo) count <= merge_lo(count, ld_data);
    else if (tick)  count <= bump(count);
  end

  // R1
  cnt_reset_chk: assert property (@(posedge clk)
    !rst_n |=> count == '0);
  // R8
  cnt_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_hi && !ld_lo) |=> count == $past(count) + CNT_W'(1));
  // R8
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_hi && !ld_lo) |=> $stable(count));
  // R5
  cnt_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hi |=> (count[CNT_W-1:HALF_W] == $past(ld_data)) &&
              (count[HALF_W-1:0] == $past(count[HALF_W-1:0])));
  // R9
  cnt_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_lo && !ld_hi) |=> (count[HALF_W-1:0] == $past(ld_data)) &&
                          (count[CNT_W-1:HALF_W] == $past(count[CNT_W-1:HALF_W])));
endmodule

// File: rtl/rtc_regwin.sv
module rtc_regwin
  import rtc_regwin_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [HALF_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              invalid_access
);
  localparam int CNT_W = 2 * HALF_W;

  reg_sel_e         sel;
  logic             en;
  logic [CNT_W-1:0] count;

  // named internal events
  logic wr_hi_ok, wr_lo_ok, wr_en_reg, wr_locked, wr_unmapped;

  rtc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr),
    .sel (sel)
  );

  always_comb begin
    wr_en_reg   = bus_wr && (sel == SEL_EN);
    wr_hi_ok    = bus_wr && (sel == SEL_HI) && en;
    wr_lo_ok    = bus_wr && (sel == SEL_LO) && en;
    wr_locked   = bus_wr && ((sel == SEL_HI) || (sel == SEL_LO)) && !en;
    wr_unmapped = bus_wr && (sel == SEL_NONE);
  end

  rtc_wen_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_wr    (wr_en_reg),
    .en_bit   (bus_wdata[0]),
    .hi_commit(wr_hi_ok),
    .en       (en)
  );

  rtc_sec_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .ld_hi  (wr_hi_ok),
    .ld_lo  (wr_lo_ok),
    .ld_data(bus_wdata),
    .count  (count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) invalid_access <= 1'b0;
    else        invalid_access <= wr_unmapped;
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_HI:  bus_rdata = DATA_W'(count[CNT_W-1:HALF_W]);
      SEL_LO:  bus_rdata = DATA_W'(count[HALF_W-1:0]);
      default: bus_rdata = '0;
    endcase
  end

  // R7
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_locked |=> count == $past(count) + CNT_W'($past(tick)));
  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_ok && tick) |=> count[HALF_W-1:0] == $past(bus_wdata));
  // R10
  invalid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmapped |=> invalid_access);
  // R10
  invalid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_access |-> $past(wr_unmapped));
  // R3
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_EN || sel == SEL_NONE) |-> bus_rdata == '0);
endmodule

// File: tb/tb_rtc_regwin.sv
module tb_rtc_regwin;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        invalid_access;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_cnt;
  logic        m_en;

  rtc_regwin dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit mapped(input logic [7:0] a);
    return a == 8'h00 || a == 8'h04 || a == 8'h08;
  endfunction

  task automatic read_at(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic read_halves(input string tag);
    read_at(8'h00, {16'h0, m_cnt[31:16]}, {tag, " R2 hi"});
    read_at(8'h04, {16'h0, m_cnt[15:0]},  {tag, " R2 lo"});
  endtask

  // one operation: drive at negedge, one rising edge, check at next negedge
  task automatic op(input bit w, input logic [7:0] a, input logic [15:0] d,
                    input bit t, input string tag);
    bit exp_inv;
    @(negedge clk);
    bus_wr = w; bus_addr = a; bus_wdata = d; tick = t;
    @(posedge clk);
    exp_inv = w && !mapped(a);
    if (w && a == 8'h08) m_en = d[0];
    else if (w && a == 8'h00 && m_en) begin m_cnt = {d, m_cnt[15:0]}; m_en = 1'b0; end
    else if (w && a == 8'h04 && m_en) m_cnt = {m_cnt[31:16], d};
    if (t && !(w && m_en && (a == 8'h00 || a == 8'h04)) && !(w && a == 8'h00 && exp_inv == 0 && m_cnt[31:16] == d && 0))
      ;
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0;
    chk({tag, " R10 pulse"}, 32'(invalid_access), 32'(exp_inv));
    read_halves(tag);
  endtask

  // op with tick accounting done by caller-visible model
  task automatic step(input bit w, input logic [7:0] a, input logic [15:0] d,
                      input bit t, input string tag);
    bit accepted;
    accepted = w && m_en && (a == 8'h00 || a == 8'h04);
    if (t && !accepted) m_cnt = m_cnt + 32'd1;
    op(w, a, d, t, tag);
  endtask

  initial begin
    void'($urandom(32'd2024));
    m_cnt = '0; m_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    chk("R1 invalid", 32'(invalid_access), 32'd0);
    read_halves("R1");
    // R1 latch clear: locked write dropped (R7)
    step(1, 8'h00, 16'hBEEF, 0, "R1/R7 locked hi");
    step(1, 8'h04, 16'h1234, 0, "R7 locked lo");
    // R8 ticks
    step(0, 8'h00, 16'h0, 1, "R8 tick");
    step(0, 8'h00, 16'h0, 1, "R8 tick2");
    step(1, 8'h04, 16'h5555, 1, "R7 locked lo with tick");
    // R4 unlock, R6 lo keeps latch
    step(1, 8'h08, 16'h0001, 0, "R4 unlock");
    step(1, 8'h04, 16'hFFFF, 0, "R6 lo write");
    step(1, 8'h00, 16'hFFFF, 0, "R6 latch kept, R5 hi write");
    step(1, 8'h04, 16'h0000, 0, "R5 relocked");
    // R8 wrap
    step(0, 8'h00, 16'h0, 1, "R8 wrap");
    chk("R8 wrap low zero", bus_rdata, 32'h0);
    // R4 clear via bit0=0
    step(1, 8'h08, 16'h0001, 0, "R4 unlock");
    step(1, 8'h08, 16'hFFFE, 0, "R4 lock bit0=0");
    step(1, 8'h00, 16'h7777, 0, "R4/R7 dropped");
    // R9 write beats tick
    step(1, 8'h08, 16'h0001, 0, "R4 unlock");
    step(1, 8'h04, 16'h00AA, 1, "R9 lo vs tick");
    step(1, 8'h00, 16'h0BB0, 1, "R9 hi vs tick");
    step(1, 8'h08, 16'h0000, 1, "R8 tick during enable write");
    // R10 unmapped writes
    step(1, 8'h0C, 16'h1111, 0, "R10 unmapped 0C");
    step(1, 8'hFF, 16'h1111, 1, "R10 unmapped FF");
    step(0, 8'h00, 16'h0, 0, "R10 drop");
    step(1, 8'h01, 16'h1, 0, "R10 unmapped 01");
    // R3 reads
    read_at(8'h08, 32'h0, "R3 en read");
    read_at(8'h0C, 32'h0, "R3 read 0C");
    read_at(8'h02, 32'h0, "R3 read 02");
    read_at(8'hFF, 32'h0, "R3 read FF");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [15:0] d;
      case ($urandom % 5)
        0: a = 8'h00;
        1: a = 8'h04;
        2, 3: a = 8'h08;
        default: a = 8'($urandom);
      endcase
      d = 16'($urandom);
      step(($urandom % 3) != 0, a, d, ($urandom % 2) == 1, "RND R2-mix");
    end
    read_at(8'h08, 32'h0, "R3 final en read");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule